// File: doc/BRIEF.md
# Machine Control and Status Register Unit

This block holds the small set of machine control and status registers that a 32-bit integer core reaches through its register-access instructions. A single access presents a 12-bit register address, a 32-bit operand and a 2-bit operation code. The operation code selects one of three ways of writing: replace the register, set bits in it, or clear bits in it. The block returns the register's value from before the access, so the core can put it into its destination register in the same cycle.

Two registers are backed by storage. The first is a 32-bit scratch word. The second is a wide event counter, of which only the low 32 bits can be read. Three counter addresses all return that same counter value, and only one of them accepts writes.

The counter moves forward by one for each retired instruction, plus the number of stall cycles the core reports for that instruction. The core decides whether an access reads at all, from its destination-is-x0 check, and whether it writes at all, from its operand-is-zero check. It passes both decisions in as enables. Every other address reads as zero and ignores writes.

Top module: `mcsr_unit`

## Requirements
- R1: After reset, both the scratch register and the counter read as zero.
- R2: Operation code 0 replaces the addressed register with the operand.
- R3: Operation code 1 writes the old value OR the operand.
- R4: Operation code 2 writes the old value AND the inverted operand.
- R5: Operation code 3 leaves every register unchanged.
- R6: csrRdata is combinational and returns the value held before the access. The scratch register is at 0x340 and the counter is at 0xB00.
- R7: Addresses 0xB01 and 0xB02 read the counter's low 32 bits. Writes to these two addresses are ignored.
- R8: Any other address reads as zero, and writes to it change nothing.
- R9: When csrValid or readEn is low, csrRdata is zero. When csrValid or writeEn is low, no register changes.
- R10: Each cycle with instrRetire high adds 1 + stallCount to the counter, where stallCount is 5 bits wide. The low 32 bits wrap modulo 2^32.
- R11: If a write to 0xB00 and an increment fall in the same cycle, the counter takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| csrValid | input | 1 | An access is presented this cycle |
| csrAddr | input | 12 | Register address |
| csrOp | input | 2 | 0 replace, 1 set bits, 2 clear bits, 3 no write |
| csrWdata | input | 32 | Operand |
| readEn | input | 1 | The access returns a value |
| writeEn | input | 1 | The access may update state |
| instrRetire | input | 1 | An instruction retires this cycle |
| stallCount | input | 5 | Stall cycles charged to the retiring instruction |
| csrRdata | output | 32 | Old value of the addressed register |

## Verification
The read value is due in the same cycle as the access, because it depends only on registered state and the current inputs. The bench samples csrRdata one time unit after driving the inputs on the falling edge, and well before the next rising edge. Every write and every counter increment becomes visible one rising edge later. The bench therefore updates its behavioural model at that edge, and the next access's read compares against it. This lets simultaneous write-and-increment cycles, counter wrap and ignored writes all be checked through the ordinary read path.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

  localparam int XLEN = 32;

  typedef enum logic [1:0] {
    OP_REPLACE = 2'd0,
    OP_SET     = 2'd1,
    OP_CLEAR   = 2'd2,
    OP_NONE    = 2'd3
  } csr_op_e;

  // Strobes handed from the control to the datapath
  typedef struct packed {
    logic    selScratch;
    logic    selCount;
    logic    wrScratch;
    logic    wrCount;
    logic    incEn;
    csr_op_e op;
  } csr_strb_t;

  function automatic logic [XLEN-1:0] mergeOp(input logic [XLEN-1:0] oldVal,
                                              input csr_op_e op,
                                              input logic [XLEN-1:0] opnd);
    logic [XLEN-1:0] res;
    case (op)
      OP_REPLACE: res = opnd;
      OP_SET:     res = oldVal | opnd;
      OP_CLEAR:   res = oldVal & ~opnd;
      default:    res = oldVal;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/mcsr_ctrl.sv
module mcsr_ctrl
  import mcsr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] SCRATCH_ADDR = 12'h340,
  parameter logic [ADDR_W-1:0] COUNT_ADDR = 12'hB00,
  parameter int NUM_ALIAS = 2,
  parameter logic [NUM_ALIAS*ADDR_W-1:0] ALIAS_ADDRS = {12'hB02, 12'hB01}
) (
  input  logic              csrValid,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [1:0]        csrOp,
  input  logic              readEn,
  input  logic              writeEn,
  input  logic              instrRetire,
  output csr_strb_t         strb
);

  logic [NUM_ALIAS-1:0] aliasHit;
  logic hitScratch;
  logic hitCount;
  logic hitAnyCount;
  logic doRead;
  logic doWrite;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_ALIAS; gi++) begin : g_alias
      assign aliasHit[gi] = (csrAddr == ALIAS_ADDRS[gi*ADDR_W +: ADDR_W]);
    end
  endgenerate

  always_comb begin
    hitScratch  = (csrAddr == SCRATCH_ADDR);
    hitCount    = (csrAddr == COUNT_ADDR);
    hitAnyCount = hitCount | (|aliasHit);
    doRead      = csrValid & readEn;
    doWrite     = csrValid & writeEn & (csr_op_e'(csrOp) != OP_NONE);

    strb.selScratch = doRead & hitScratch;
    strb.selCount   = doRead & hitAnyCount;
    strb.wrScratch  = doWrite & hitScratch;
    strb.wrCount    = doWrite & hitCount;
    strb.incEn      = instrRetire;
    strb.op         = csr_op_e'(csrOp);
  end

endmodule

// File: rtl/mcsr_dp.sv
module mcsr_dp
  import mcsr_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int STALL_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  csr_strb_t         strb,
  input  logic [XLEN-1:0]   csrWdata,
  input  logic [STALL_W-1:0] stallCount,
  output logic [XLEN-1:0]   csrRdata,
  output logic [XLEN-1:0]   scratchVal,
  output logic [XLEN-1:0]   countLo
);

  localparam int PAD_W = CNT_W - STALL_W;

  logic [XLEN-1:0]  scratchQ;
  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] countWr;
  logic [CNT_W-1:0] countInc;
  logic [XLEN-1:0]  countMerged;

  assign countMerged = mergeOp(countQ[XLEN-1:0], strb.op, csrWdata);
  assign countInc = countQ + CNT_W'(1) + {{PAD_W{1'b0}}, stallCount};

  // A software write touches the low word; wider counters keep the upper part
  generate
    if (CNT_W > XLEN) begin : g_wide
      assign countWr = {countQ[CNT_W-1:XLEN], countMerged};
    end else begin : g_narrow
      assign countWr = countMerged;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scratchQ <= '0;
    end else if (strb.wrScratch) begin
      scratchQ <= mergeOp(scratchQ, strb.op, csrWdata);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strb.wrCount) begin
      countQ <= countWr;
    end else if (strb.incEn) begin
      countQ <= countInc;
    end
  end

  always_comb begin
    if (strb.selScratch)    csrRdata = scratchQ;
    else if (strb.selCount) csrRdata = countQ[XLEN-1:0];
    else                    csrRdata = '0;
  end

  assign scratchVal = scratchQ;
  assign countLo    = countQ[XLEN-1:0];

endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
  import mcsr_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int STALL_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csrValid,
  input  logic [11:0]        csrAddr,
  input  logic [1:0]         csrOp,
  input  logic [31:0]        csrWdata,
  input  logic               readEn,
  input  logic               writeEn,
  input  logic               instrRetire,
  input  logic [STALL_W-1:0] stallCount,
  output logic [31:0]        csrRdata
);

  csr_strb_t strb;
  logic [XLEN-1:0] scratchVal;
  logic [XLEN-1:0] countLo;

  mcsr_ctrl u_ctrl (
    .csrValid    (csrValid),
    .csrAddr     (csrAddr),
    .csrOp       (csrOp),
    .readEn      (readEn),
    .writeEn     (writeEn),
    .instrRetire (instrRetire),
    .strb        (strb)
  );

  mcsr_dp #(.CNT_W(CNT_W), .STALL_W(STALL_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .csrWdata   (csrWdata),
    .stallCount (stallCount),
    .csrRdata   (csrRdata),
    .scratchVal (scratchVal),
    .countLo    (countLo)
  );

endmodule

// File: rtl/mcsr_chk.sv
module mcsr_chk #(
  parameter int STALL_W = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               csrValid,
  input logic [11:0]        csrAddr,
  input logic [1:0]         csrOp,
  input logic [31:0]        csrWdata,
  input logic               readEn,
  input logic               writeEn,
  input logic               instrRetire,
  input logic [STALL_W-1:0] stallCount,
  input logic [31:0]        csrRdata,
  input logic [31:0]        scratchVal,
  input logic [31:0]        countLo
);

  logic cntWrite;
  assign cntWrite = csrValid && writeEn && (csrOp != 2'd3) && (csrAddr == 12'hB00);

  // R9
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(csrValid && readEn) |-> csrRdata == 32'd0);

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr != 12'h340 && csrAddr != 12'hB00 && csrAddr != 12'hB01 &&
     csrAddr != 12'hB02) |-> csrRdata == 32'd0);

  // R7
  alias_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && readEn && (csrAddr == 12'hB01 || csrAddr == 12'hB02)) |->
      csrRdata == countLo);

  // R10
  count_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrRetire && !cntWrite) |=>
      countLo == $past(countLo) + 32'd1 + 32'($past(stallCount)));

  // R11
  write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntWrite && csrOp == 2'd0) |=> countLo == $past(csrWdata));

  // R5
  no_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrOp == 2'd3) |=> $stable(scratchVal));

endmodule

bind mcsr_unit mcsr_chk #(.STALL_W(STALL_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .csrValid    (csrValid),
  .csrAddr     (csrAddr),
  .csrOp       (csrOp),
  .csrWdata    (csrWdata),
  .readEn      (readEn),
  .writeEn     (writeEn),
  .instrRetire (instrRetire),
  .stallCount  (stallCount),
  .csrRdata    (csrRdata),
  .scratchVal  (scratchVal),
  .countLo     (countLo)
);

// File: tb/mcsr_unit_tb.sv
module mcsr_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrValid = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [1:0]  csrOp = '0;
  logic [31:0] csrWdata = '0;
  logic        readEn = 1'b0;
  logic        writeEn = 1'b0;
  logic        instrRetire = 1'b0;
  logic [4:0]  stallCount = '0;
  logic [31:0] csrRdata;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  logic [31:0]   refScratch = '0;
  longint unsigned refCount = 0;

  always #5 clk = ~clk;

  mcsr_unit dut_i (
    .clk(clk), .rstN(rstN), .csrValid(csrValid), .csrAddr(csrAddr),
    .csrOp(csrOp), .csrWdata(csrWdata), .readEn(readEn), .writeEn(writeEn),
    .instrRetire(instrRetire), .stallCount(stallCount), .csrRdata(csrRdata)
  );

  function automatic logic [31:0] refMerge(logic [31:0] o, logic [1:0] op, logic [31:0] d);
    if (op == 2'd0) return d;
    if (op == 2'd1) return o | d;
    if (op == 2'd2) return o & ~d;
    return o;
  endfunction

  function automatic logic [31:0] refRead(logic v, logic r, logic [11:0] a);
    if (!(v && r)) return 32'd0;
    if (a == 12'h340) return refScratch;
    if (a == 12'hB00 || a == 12'hB01 || a == 12'hB02) return refCount[31:0];
    return 32'd0;
  endfunction

  // One access: drive on falling edge, check read value, update model at rising edge
  task automatic cyc(input string tag, input logic v, input logic [11:0] a,
                     input logic [1:0] op, input logic [31:0] d, input logic r,
                     input logic w, input logic ret, input logic [4:0] st);
    logic [31:0] exp;
    @(negedge clk);
    csrValid = v; csrAddr = a; csrOp = op; csrWdata = d;
    readEn = r; writeEn = w; instrRetire = ret; stallCount = st;
    #1;
    exp = refRead(v, r, a);
    checks++;
    if (csrRdata !== exp) begin
      errors++;
      $display("FAIL %s: addr=%h actual=%h expected=%h", tag, a, csrRdata, exp);
    end
    @(posedge clk);
    if (v && w && op != 2'd3 && a == 12'h340) refScratch = refMerge(refScratch, op, d);
    if (v && w && op != 2'd3 && a == 12'hB00)
      refCount = {refCount[63:32], refMerge(refCount[31:0], op, d)};
    else if (ret)
      refCount = refCount + 64'd1 + 64'(st);
  endtask

  task automatic rd(input string tag, input logic [11:0] a);
    cyc(tag, 1'b1, a, 2'd3, 32'h0, 1'b1, 1'b0, 1'b0, 5'd0);
  endtask

  task automatic wr(input string tag, input logic [11:0] a, input logic [1:0] op,
                    input logic [31:0] d);
    cyc(tag, 1'b1, a, op, d, 1'b1, 1'b1, 1'b0, 5'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd("R1 scratch", 12'h340);
    rd("R1 counter", 12'hB00);

    // R2 replace, R6 old value returned
    wr("R2 write scratch", 12'h340, 2'd0, 32'hA5A5_0F0F);
    wr("R6 old value on replace", 12'h340, 2'd0, 32'h1234_5678);
    rd("R2 readback", 12'h340);

    // R3 set bits
    wr("R3 set", 12'h340, 2'd1, 32'hF000_0001);
    rd("R3 readback", 12'h340);

    // R4 clear bits
    wr("R4 clear", 12'h340, 2'd2, 32'h1000_0070);
    rd("R4 readback", 12'h340);

    // R5 op 3 changes nothing
    wr("R5 no-op scratch", 12'h340, 2'd3, 32'hFFFF_FFFF);
    rd("R5 readback", 12'h340);
    wr("R5 no-op counter", 12'hB00, 2'd3, 32'hDEAD_BEEF);
    rd("R5 counter readback", 12'hB00);

    // R9 read gate and write gate
    cyc("R9 read disabled", 1'b1, 12'h340, 2'd3, 32'h0, 1'b0, 1'b0, 1'b0, 5'd0);
    cyc("R9 write disabled", 1'b1, 12'h340, 2'd0, 32'h0BAD_0BAD, 1'b1, 1'b0, 1'b0, 5'd0);
    cyc("R9 valid low", 1'b0, 12'h340, 2'd0, 32'h0BAD_0BAD, 1'b1, 1'b1, 1'b0, 5'd0);
    rd("R9 state kept", 12'h340);

    // R8 unmapped addresses
    wr("R8 write unmapped", 12'h341, 2'd0, 32'hCAFE_F00D);
    rd("R8 read unmapped", 12'h341);
    rd("R8 read unmapped 2", 12'h000);
    rd("R8 scratch untouched", 12'h340);

    // R10 increments
    wr("R10 counter load", 12'hB00, 2'd0, 32'd100);
    cyc("R10 retire 0", 1'b0, 12'h0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b1, 5'd0);
    cyc("R10 retire 7", 1'b0, 12'h0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b1, 5'd7);
    rd("R10 after retires", 12'hB00);
    cyc("R10 retire while reading", 1'b1, 12'hB00, 2'd3, 32'h0, 1'b1, 1'b0, 1'b1, 5'd31);
    rd("R10 max stall", 12'hB00);

    // R7 aliases read counter; writes ignored
    rd("R7 alias B01", 12'hB01);
    rd("R7 alias B02", 12'hB02);
    wr("R7 write alias B01", 12'hB01, 2'd0, 32'h5555_5555);
    wr("R7 write alias B02", 12'hB02, 2'd1, 32'hFFFF_FFFF);
    rd("R7 counter unchanged", 12'hB00);

    // R3/R4 on the counter
    wr("R3 set counter", 12'hB00, 2'd1, 32'h8000_0000);
    wr("R4 clear counter", 12'hB00, 2'd2, 32'h0000_00FF);
    rd("R4 counter readback", 12'hB00);

    // R11 write beats increment
    cyc("R11 write with retire", 1'b1, 12'hB00, 2'd0, 32'h0000_0400, 1'b1, 1'b1, 1'b1, 5'd9);
    rd("R11 written value", 12'hB00);
    cyc("R11 scratch write with retire", 1'b1, 12'h340, 2'd0, 32'h7, 1'b1, 1'b1, 1'b1, 5'd2);
    rd("R11 counter still counts", 12'hB00);

    // R10 wrap of the low word
    wr("R10 near wrap", 12'hB00, 2'd0, 32'hFFFF_FFF0);
    cyc("R10 wrap step", 1'b0, 12'h0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b1, 5'd31);
    rd("R10 wrapped", 12'hB00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule